// File: doc/BRIEF.md
# Passive Serial Configuration Sequencer

This block loads a configuration bitstream into a programmable logic device through its passive serial pins. A one-cycle start pulse, together with a byte count, begins a load. The sequencer first pulls the device's configuration-request line low for a parameterised interval and then releases it. It waits for the device's status line to rise, and then shifts the bitstream bytes out one bit per serial clock. The bytes come from a valid/ready byte stream.

After the last data byte, the sequencer sends one extra byte of serial clocks so the device has clocks to start up. It then waits for the configuration-done line. The load ends with exactly one of three results: done, configuration error or timeout. Every interval is a count of system clock cycles set by a parameter, and the two device inputs are synchronised before use. `LOW_CYC` must be at least 2 so that the synchroniser sees the status line fall.

States: `ST_IDLE`, `ST_CFG_LOW` (request line low), `ST_WAIT_STAT` (waiting for status high), `ST_FETCH` (waiting for a stream byte), `ST_SHIFT` (byte on the wire), `ST_TAIL_KICK` (launch the trailing byte), `ST_TAIL` (trailing clocks), and `ST_WAIT_CONF` (waiting for done).

Transitions:
- IDLE→CFG_LOW on start.
- CFG_LOW→WAIT_STAT when the timer expires.
- WAIT_STAT→FETCH, or →TAIL_KICK when no bytes remain, on status high.
- WAIT_STAT→IDLE with timeout when the timer expires first.
- FETCH→SHIFT on a stream handshake.
- SHIFT→FETCH or →TAIL_KICK when the shifter goes idle.
- TAIL_KICK→TAIL.
- TAIL→WAIT_CONF when the shifter goes idle.
- WAIT_CONF→IDLE with error, done or timeout.

Top module: `ps_cfg_seq`

## Requirements
- R1: After reset and whenever idle, `ncfg_o` is 1, `dclk_o` is 0, `s_ready_o` is 0 and `busy_o` is 0. After reset, `done_o`, `err_o` and `tmo_o` are all 0.
- R2: A start pulse while idle clears all three status outputs. It then holds `ncfg_o` low for exactly LOW_CYC+1 clock cycles, after which `ncfg_o` returns high.
- R3: No rising edge of `dclk_o` occurs until `nstatus_i` (after a two-flop synchroniser) is seen high following the release. If it is not seen high within STAT_CYC+1 cycles, the load ends with `tmo_o`=1 and no serial clocks.
- R4: Each byte is sent least significant bit first: bit i of byte k is the value of `data0_o` at rising edge 8k+i of `dclk_o`. `data0_o` is stable across each rising edge. `dclk_o` is high for DIV_HALF cycles and low for DIV_HALF cycles.
- R5: After the last data byte, exactly 8 further rising edges of `dclk_o` are sent with `data0_o`=1. No stream byte is requested during them.
- R6: Exactly `byte_cnt_i` bytes are accepted from the stream (`s_valid_i` and `s_ready_o` both high at a clock edge). `s_ready_o` is high only while `dclk_o` is low.
- R7: After the trailing clocks, a synchronised `confdone_i` high ends the load with `done_o`=1.
- R8: While waiting for done, a synchronised `nstatus_i` low ends the load with `err_o`=1. It takes priority over `confdone_i` in the same cycle.
- R9: If `confdone_i` is not seen high within DONE_CYC+1 cycles after the trailing clocks end, the load ends with `tmo_o`=1.
- R10: At most one of `done_o`, `err_o` and `tmo_o` is 1. Each holds its value until the next accepted start.
- R11: A start pulse while `busy_o`=1 is ignored: no second request pulse is made, and the byte count is not reloaded.
- R12: A byte count of 0 still makes the request pulse, the status handshake, the 8 trailing clocks and the done wait, and accepts no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| byte_cnt_i | input | CNT_W | Number of bitstream bytes, sampled at start |
| s_data_i | input | 8 | Stream byte |
| s_valid_i | input | 1 | Stream byte valid |
| s_ready_o | output | 1 | Sequencer ready for a stream byte |
| ncfg_o | output | 1 | Configuration request to device, active low |
| dclk_o | output | 1 | Serial configuration clock |
| data0_o | output | 1 | Serial configuration data |
| nstatus_i | input | 1 | Device status, low means reset or error |
| confdone_i | input | 1 | Device configuration done |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load finished with success |
| err_o | output | 1 | Load finished with configuration error |
| tmo_o | output | 1 | Load finished with timeout |

## Verification
The request line goes low in the cycle after the start edge and stays low for LOW_CYC+1 cycles. The bench therefore counts low cycles at falling clock edges and expects that exact number.

Serial data is captured at each rising `dclk_o` edge by a device model. That model only releases its status line a random delay after the request rises, so any clock seen earlier is counted as a violation. A stream byte counts as accepted when `s_ready_o` is high at the falling edge before the accepting rising edge.

Result outputs are read at the first falling edge where `busy_o` is low, and read again ten cycles later to confirm they hold. For the done-wait timeout, the gap from the last trailing clock rise to the end of the load must lie between DONE_CYC and DONE_CYC+DIV_HALF+4 cycles. This window covers the shifter's final half period and the two state changes.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CFG_LOW,
        ST_WAIT_STAT,
        ST_FETCH,
        ST_SHIFT,
        ST_TAIL_KICK,
        ST_TAIL,
        ST_WAIT_CONF
    } ps_state_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ps_sync2.sv
module ps_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= d_i[i];
                stab_q <= meta_q;
            end
        end
        assign q_o[i] = stab_q;
    end
endmodule

// File: rtl/ps_timer.sv
module ps_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ps_shift.sv
module ps_shift #(
    parameter int DIV_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld_i,
    input  logic [7:0] byte_i,
    output logic       dclk_o,
    output logic       data_o,
    output logic       idle_o
);
    localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(DIV_HALF - 1);

    logic [7:0]    sreg_q;
    logic [2:0]    bit_q;
    logic [DW-1:0] div_q;
    logic          dclk_q;
    logic          act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            bit_q  <= '0;
            div_q  <= '0;
            dclk_q <= 1'b0;
            act_q  <= 1'b0;
        end else if (!act_q) begin
            if (ld_i) begin
                sreg_q <= byte_i;
                bit_q  <= '0;
                div_q  <= '0;
                dclk_q <= 1'b0;
                act_q  <= 1'b1;
            end
        end else if (div_q == DIV_LAST) begin
            div_q <= '0;
            if (!dclk_q) begin
                dclk_q <= 1'b1;
            end else begin
                dclk_q <= 1'b0;
                if (bit_q == 3'd7) begin
                    act_q <= 1'b0;
                end else begin
                    bit_q  <= bit_q + 3'd1;
                    sreg_q <= {1'b0, sreg_q[7:1]};
                end
            end
        end else begin
            div_q <= div_q + DW'(1);
        end
    end

    assign dclk_o = dclk_q;
    assign data_o = sreg_q[0];
    assign idle_o = !act_q;

    // R4: data must not move at the rising clock edge
    a_r4_data_stable_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dclk_o) |-> $stable(data_o));

    // R1: the serial clock rests low whenever no byte is in flight
    a_r1_clock_rests_low: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> !dclk_o);
endmodule

// File: rtl/ps_cfg_seq.sv
module ps_cfg_seq
    import ps_cfg_pkg::*;
#(
    parameter int DIV_HALF = 2,
    parameter int LOW_CYC  = 10000,
    parameter int STAT_CYC = 40000,
    parameter int DONE_CYC = 400000,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] byte_cnt_i,
    input  logic [7:0]       s_data_i,
    input  logic             s_valid_i,
    output logic             s_ready_o,
    output logic             ncfg_o,
    output logic             dclk_o,
    output logic             data0_o,
    input  logic             nstatus_i,
    input  logic             confdone_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic             tmo_o
);
    localparam int MAXC = max3(LOW_CYC, STAT_CYC, DONE_CYC);
    localparam int TW   = $clog2(MAXC + 1);

    ps_state_t        state_q, state_d;
    logic [CNT_W-1:0] rem_q;
    logic [1:0]       pins_s;
    logic             stat_s, conf_s;
    logic             tmr_ld, tmr_zero;
    logic [TW-1:0]    tmr_val;
    logic             sh_ld, sh_idle;
    logic [7:0]       sh_byte;
    logic             fin_done, fin_err, fin_tmo;
    logic             done_q, err_q, tmo_q;

    ps_sync2 #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({confdone_i, nstatus_i}),
        .q_o   (pins_s)
    );
    assign stat_s = pins_s[0];
    assign conf_s = pins_s[1];

    ps_timer #(.W(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_i   (tmr_ld),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    ps_shift #(.DIV_HALF(DIV_HALF)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_i   (sh_ld),
        .byte_i (sh_byte),
        .dclk_o (dclk_o),
        .data_o (data0_o),
        .idle_o (sh_idle)
    );

    always_comb begin
        state_d  = state_q;
        tmr_ld   = 1'b0;
        tmr_val  = '0;
        sh_ld    = 1'b0;
        sh_byte  = s_data_i;
        fin_done = 1'b0;
        fin_err  = 1'b0;
        fin_tmo  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_CFG_LOW;
                    tmr_ld  = 1'b1;
                    tmr_val = TW'(LOW_CYC);
                end
            end
            ST_CFG_LOW: begin
                if (tmr_zero) begin
                    state_d = ST_WAIT_STAT;
                    tmr_ld  = 1'b1;
                    tmr_val = TW'(STAT_CYC);
                end
            end
            ST_WAIT_STAT: begin
                if (stat_s) begin
                    state_d = (rem_q == '0) ? ST_TAIL_KICK : ST_FETCH;
                end else if (tmr_zero) begin
                    state_d = ST_IDLE;
                    fin_tmo = 1'b1;
                end
            end
            ST_FETCH: begin
                if (s_valid_i) begin
                    sh_ld   = 1'b1;
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (sh_idle) begin
                    state_d = (rem_q == '0) ? ST_TAIL_KICK : ST_FETCH;
                end
            end
            ST_TAIL_KICK: begin
                sh_ld   = 1'b1;
                sh_byte = 8'hFF;
                state_d = ST_TAIL;
            end
            ST_TAIL: begin
                if (sh_idle) begin
                    state_d = ST_WAIT_CONF;
                    tmr_ld  = 1'b1;
                    tmr_val = TW'(DONE_CYC);
                end
            end
            ST_WAIT_CONF: begin
                if (!stat_s) begin
                    state_d = ST_IDLE;
                    fin_err = 1'b1;
                end else if (conf_s) begin
                    state_d  = ST_IDLE;
                    fin_done = 1'b1;
                end else if (tmr_zero) begin
                    state_d = ST_IDLE;
                    fin_tmo = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and byte counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                rem_q <= byte_cnt_i;
            end else if (state_q == ST_FETCH && s_valid_i) begin
                rem_q <= rem_q - CNT_W'(1);
            end
        end
    end

    // result outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            tmo_q  <= 1'b0;
        end else if (state_q == ST_IDLE && start_i) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            tmo_q  <= 1'b0;
        end else begin
            if (fin_done) done_q <= 1'b1;
            if (fin_err)  err_q  <= 1'b1;
            if (fin_tmo)  tmo_q  <= 1'b1;
        end
    end

    assign ncfg_o    = (state_q != ST_CFG_LOW);
    assign s_ready_o = (state_q == ST_FETCH);
    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = done_q;
    assign err_o     = err_q;
    assign tmo_o     = tmo_q;

    // R10: at most one result flag
    a_r10_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, err_o, tmo_o}));

    // R10: results hold while idle with no start
    a_r10_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable({done_o, err_o, tmo_o}));

    // R1: idle pins
    a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (ncfg_o && !dclk_o && !s_ready_o));

    // R3: no serial clock before the status handshake
    a_r3_no_clock_before_status: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CFG_LOW || state_q == ST_WAIT_STAT) |-> !dclk_o);

    // R5: trailing clocks carry ones
    a_r5_tail_data_one: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAIL) |-> data0_o);

    // R6: a byte is requested only with the clock low
    a_r6_ready_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> !dclk_o);

    // R11: a start while busy never restarts the request pulse
    a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ncfg_o && start_i) |=> ncfg_o);
endmodule

// File: tb/ps_cfg_seq_test.sv
module ps_cfg_seq_test;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int HALF = 2;
    localparam int LOWC = 20;
    localparam int STAC = 60;
    localparam int DONC = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [15:0] byte_cnt_i = '0;
    logic [7:0] s_data_i = '0;
    logic       s_valid_i = 1'b0;
    logic       s_ready_o, ncfg_o, dclk_o, data0_o;
    logic       nstatus_i, confdone_i;
    logic       busy_o, done_o, err_o, tmo_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    logic [7:0] exp_b [0:15];
    logic       bits  [0:255];
    int nbits = 0;
    int low_cnt = 0;
    int early_clk = 0;
    int last_rise = 0;
    int taken = 0;
    int tgt_mode = 0;
    int tgt_bits = 0;
    int st_delay = 5;
    bit tgt_err = 0;

    always #2.5 clk = ~clk;

    ps_cfg_seq #(
        .DIV_HALF(HALF), .LOW_CYC(LOWC), .STAT_CYC(STAC), .DONE_CYC(DONC), .CNT_W(16)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_cnt_i(byte_cnt_i),
        .s_data_i(s_data_i), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
        .ncfg_o(ncfg_o), .dclk_o(dclk_o), .data0_o(data0_o),
        .nstatus_i(nstatus_i), .confdone_i(confdone_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .tmo_o(tmo_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // device model: bit capture
    initial forever begin
        @(posedge dclk_o);
        if (nbits < 256) bits[nbits] = data0_o;
        nbits++;
        last_rise = cyc;
        if (!nstatus_i) early_clk++;
    end

    // device model: status and done lines
    initial begin
        int rel;
        int post;
        rel = 0;
        post = 0;
        nstatus_i = 1'b1;
        confdone_i = 1'b0;
        forever begin
            @(negedge clk);
            if (!ncfg_o) begin
                low_cnt++;
                nstatus_i = 1'b0;
                confdone_i = 1'b0;
                rel = 0;
                post = 0;
            end else begin
                if (!nstatus_i && tgt_mode != 1 && !tgt_err) begin
                    rel++;
                    if (rel >= st_delay) nstatus_i = 1'b1;
                end
                if (nstatus_i && nbits >= tgt_bits) begin
                    post++;
                    if (tgt_mode == 0 && post >= 25) confdone_i = 1'b1;
                    if (tgt_mode == 2 && post >= 10) begin
                        nstatus_i = 1'b0;
                        tgt_err = 1'b1;
                    end
                end
            end
        end
    end

    function automatic logic [7:0] cap_byte(input int k);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[i] = bits[8*k + i];
        return v;
    endfunction

    task automatic run_load(input int n, input int mode, input bit restart_mid);
        bit rs;
        int gap_max;
        rs = 0;
        gap_max = $urandom_range(0, 4);
        for (int k = 0; k < n; k++) exp_b[k] = 8'($urandom_range(0, 255));
        tgt_mode = mode;
        tgt_bits = 8 * (n + 1);
        tgt_err = 0;
        st_delay = $urandom_range(3, 30);
        nbits = 0;
        low_cnt = 0;
        early_clk = 0;
        taken = 0;
        @(negedge clk);
        byte_cnt_i = 16'(n);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        byte_cnt_i = 16'hFFFF;
        fork
            begin
                for (int k = 0; k < n; k++) begin
                    if (!busy_o) break;
                    repeat ($urandom_range(0, gap_max)) @(negedge clk);
                    s_data_i = exp_b[k];
                    s_valid_i = 1'b1;
                    while (!s_ready_o && busy_o) @(negedge clk);
                    if (s_ready_o) begin
                        taken++;
                        @(negedge clk);
                    end
                    s_valid_i = 1'b0;
                end
            end
            begin
                while (busy_o) begin
                    @(negedge clk);
                    if (restart_mid && !rs && nbits >= 3) begin
                        start_i = 1'b1;
                        @(negedge clk);
                        start_i = 1'b0;
                        rs = 1;
                    end
                end
            end
        join
        // R2: single request pulse of fixed length
        chk(low_cnt == LOWC + 1, "R2", "nCONFIG low cycles", low_cnt, LOWC + 1);
        // R3: no clock before the device released status
        chk(early_clk == 0, "R3", "clocks before status high", early_clk, 0);
        if (mode == 1) begin
            chk(tmo_o && !done_o && !err_o, "R3", "status timeout flag", tmo_o, 1);
            chk(nbits == 0, "R3", "clocks after status timeout", nbits, 0);
        end else begin
            chk(nbits == 8 * (n + 1), "R5", "rising edges total", nbits, 8 * (n + 1));
            chk(taken == n, "R6", "bytes accepted", taken, n);
            for (int k = 0; k < n; k++)
                chk(cap_byte(k) == exp_b[k], "R4", "byte LSB first",
                    int'(cap_byte(k)), int'(exp_b[k]));
            chk(cap_byte(n) == 8'hFF, "R5", "trailing byte ones", int'(cap_byte(n)), 255);
            if (mode == 0)
                chk(done_o && !err_o && !tmo_o, "R7", "done flag", done_o, 1);
            if (mode == 2)
                chk(err_o && !done_o && !tmo_o, "R8", "error flag", err_o, 1);
            if (mode == 3) begin
                chk(tmo_o && !done_o && !err_o, "R9", "done wait timeout flag", tmo_o, 1);
                chk((cyc - last_rise) >= DONC && (cyc - last_rise) <= DONC + HALF + 4,
                    "R9", "done wait length", cyc - last_rise, DONC);
            end
        end
        begin
            logic [2:0] st;
            st = {done_o, err_o, tmo_o};
            repeat (10) @(negedge clk);
            chk({done_o, err_o, tmo_o} == st, "R10", "status hold", int'({done_o, err_o, tmo_o}), int'(st));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ncfg_o && !dclk_o && !s_ready_o && !busy_o, "R1", "idle pins", int'({ncfg_o, dclk_o, s_ready_o, busy_o}), 8);
        chk(!done_o && !err_o && !tmo_o, "R1", "reset status", int'({done_o, err_o, tmo_o}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ncfg_o && !dclk_o && !busy_o, "R1", "idle after reset", int'({ncfg_o, dclk_o, busy_o}), 4);

        for (int t = 0; t < 8; t++) run_load($urandom_range(1, 10), 0, 0);
        run_load(0, 0, 0);   // R12: zero count
        chk(taken == 0 && nbits == 8, "R12", "zero count tail only", nbits, 8);
        run_load(5, 0, 1);   // R11: start while busy ignored
        chk(done_o, "R11", "load completes despite restart", done_o, 1);
        run_load(3, 1, 0);   // R3: status never rises
        run_load(4, 2, 0);   // R8: error during done wait
        run_load(2, 3, 0);   // R9: done never rises
        run_load(6, 0, 0);   // R2: new start clears previous result
        chk(!tmo_o && done_o, "R2", "previous status cleared", int'({done_o, tmo_o}), 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule